// File: doc/BRIEF.md
# System Control Register Block

This block is the mandatory coprocessor-0 register set of a 32-bit core. It holds eight 32-bit registers reached through a 3-bit index: the current privilege mode, a fixed version word, a core identity word built from parameters, a word of unit present/enable flags, and three exception registers (cause, return address and vector base). The core reads any register combinationally through a separate read index and writes through a single-cycle write strobe.

A dedicated exception-entry pulse captures the cause and faulting address and raises the mode to kernel, leaving hypervisor mode alone. Writes are honoured only from kernel or hypervisor mode. A write from user or system mode is discarded, and a one-cycle privilege-fault pulse reports it. Both the register port and the exception pulse are plain control strobes with no valid/ready handshake. The block accepts one access every cycle and never applies back-pressure, so the core never has to hold a request.

The MMU, cache-control, FPU and vector units are not part of this block. They appear only as present flags set by parameters and as enable flags that software may set.

Top module: `sysctl_regs`

## Requirements
- R1: After reset the mode is kernel (2'b10), the cause, return-address and vector registers read 0, and the only enable flag set is the SCU enable (bit 16).
- R2: `rd_data` shows the register chosen by `rd_idx` in the same cycle. The index map is 0 mode control, 1 reserved, 2 version, 3 identity, 4 feature flags, 5 cause, 6 return address, 7 vector base.
- R3: Index 0 holds the mode in bits 1:0, with 00 user, 01 system, 10 kernel and 11 hypervisor. Its bits 31:2 always read 0, and a write to those bits has no effect.
- R4: Index 2 always reads 0x72337600. Writes to it have no effect.
- R5: Index 3 reads {8'h00, CORE_COUNT[11:0], CORE_ID[11:0]}, so the defaults (core 4 of 8) give 0x00008004. Writes to it have no effect.
- R6: At index 4, bits 5:0 are present flags in the order bit 0 SCU, bit 1 reserved (0), bit 2 MMU, bit 3 cache control, bit 4 FPU, bit 5 vector. They come from parameters and writes do not change them. Bits 21:16 are the matching enable flags, and every other bit reads 0.
- R7: The SCU present bit (bit 0) and the SCU enable bit (bit 16) at index 4 always read 1.
- R8: A write to index 4 sets an enable flag (bits 18..21) only when the matching present parameter is 1. An enable flag for an absent unit, and bit 17, always read 0.
- R9: Index 1 always reads 0. Writes to it have no effect.
- R10: A write takes effect only when the current mode is kernel or hypervisor. A write attempted from user or system mode changes nothing, and `priv_fault` is high for exactly the cycle after the attempt.
- R11: An exception-entry pulse loads `exc_cause` into index 5 and `exc_pc` into index 6. On the next cycle the mode is kernel, unless the mode was hypervisor, in which case it stays hypervisor.
- R12: When an exception-entry pulse and a write occur in the same cycle, the exception wins. The write is discarded and raises no privilege fault.
- R13: Indices 5, 6 and 7 accept all 32 written bits from a privileged mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_idx | input | 3 | Register index for the write |
| wr_data | input | 32 | Write data |
| rd_idx | input | 3 | Register index for the combinational read |
| rd_data | output | 32 | Read data |
| exc_take | input | 1 | Exception-entry pulse |
| exc_cause | input | 32 | Cause value captured on exception entry |
| exc_pc | input | 32 | Faulting address captured on exception entry |
| mode | output | 2 | Current privilege mode |
| priv_fault | output | 1 | One-cycle pulse after a write attempted without privilege |

## Verification
On every cycle, the assertions check four things. The mode changes only after a write or an exception. An exception leaves the mode at kernel or hypervisor and fills the cause and return-address registers. A privilege fault is never accompanied by a mode change. The enable flags never include a unit that is absent.

Some behaviours can only be shown by the bench scenarios. These are the exact read values of the version and identity words, the discarding of writes to read-only fields and reserved bits, the priority of an exception over a write in the same cycle, and the reset contents.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned IDX_W     = 3;
  localparam int unsigned NUNITS    = 6;
  localparam int unsigned EN_LSB    = 16;
  localparam int unsigned ID_FLD_W  = 12;
  localparam logic [XLEN-1:0] VERSION_WORD = 32'h7233_7600;

  typedef enum logic [1:0] {
    MODE_USER = 2'b00,
    MODE_SYS  = 2'b01,
    MODE_KERN = 2'b10,
    MODE_HYP  = 2'b11
  } mode_e;

  localparam logic [IDX_W-1:0] IX_CTRL  = 3'd0;
  localparam logic [IDX_W-1:0] IX_RSVD  = 3'd1;
  localparam logic [IDX_W-1:0] IX_VER   = 3'd2;
  localparam logic [IDX_W-1:0] IX_IDENT = 3'd3;
  localparam logic [IDX_W-1:0] IX_FEAT  = 3'd4;
  localparam logic [IDX_W-1:0] IX_CAUSE = 3'd5;
  localparam logic [IDX_W-1:0] IX_EPC   = 3'd6;
  localparam logic [IDX_W-1:0] IX_VEC   = 3'd7;
endpackage

// File: rtl/sysctl_mode_ctl.sv
module sysctl_mode_ctl
  import sysctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_req,
  input  logic       wr_ctrl,
  input  logic [1:0] wr_mode,
  input  logic       exc_take,
  output mode_e      mode_o,
  output logic       wr_ok_o,
  output logic       priv_fault_o
);
  mode_e mode_q;
  logic  privileged;
  logic  fault_q;

  assign privileged = (mode_q == MODE_KERN) || (mode_q == MODE_HYP);
  assign wr_ok_o    = wr_req && !exc_take && privileged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_KERN;
      fault_q <= 1'b0;
    end else begin
      fault_q <= wr_req && !exc_take && !privileged;
      if (exc_take) begin
        if (mode_q != MODE_HYP) mode_q <= MODE_KERN;
      end else if (wr_ok_o && wr_ctrl) begin
        mode_q <= mode_e'(wr_mode);
      end
    end
  end

  assign mode_o       = mode_q;
  assign priv_fault_o = fault_q;

  // R11: exception entry leaves the core at kernel or keeps hypervisor
  assert_exc_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (mode_q == ($past(mode_q) == MODE_HYP ? MODE_HYP : MODE_KERN)));

  // R10: mode moves only on a write or an exception
  assert_mode_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req || exc_take) |=> $stable(mode_q));
endmodule

// File: rtl/sysctl_feature.sv
module sysctl_feature
  import sysctl_pkg::*;
#(
  parameter logic [NUNITS-1:0] PRESENT = 6'b010101
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_feat,
  input  logic [NUNITS-1:0]    wr_en_bits,
  output logic [XLEN-1:0]      feat_word
);
  logic [NUNITS-1:0] pres;
  logic [NUNITS-1:0] enab;

  for (genvar u = 0; u < NUNITS; u++) begin : g_unit
    if (u == 0) begin : g_scu
      assign pres[u] = 1'b1;
      assign enab[u] = 1'b1;
    end else if (PRESENT[u] && u != 1) begin : g_opt
      logic en_q;
      assign pres[u] = 1'b1;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (wr_feat) en_q <= wr_en_bits[u];
      end
      assign enab[u] = en_q;
    end else begin : g_absent
      assign pres[u] = 1'b0;
      assign enab[u] = 1'b0;
    end
  end

  always_comb begin
    feat_word = '0;
    feat_word[NUNITS-1:0]               = pres;
    feat_word[EN_LSB +: NUNITS]         = enab;
  end

  // R8: no enable flag without its unit
  assert_en_subset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enab & ~pres) == '0);
  // R7: SCU flags stay set
  assert_scu_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_feat |=> (feat_word[0] && feat_word[EN_LSB]));
endmodule

// File: rtl/sysctl_exc_regs.sv
module sysctl_exc_regs
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_take,
  input  logic [XLEN-1:0]  exc_cause,
  input  logic [XLEN-1:0]  exc_pc,
  input  logic             wr_ok,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  output logic [XLEN-1:0]  cause_o,
  output logic [XLEN-1:0]  epc_o,
  output logic [XLEN-1:0]  vec_o
);
  logic [XLEN-1:0] cause_q, epc_q, vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      epc_q   <= '0;
      vec_q   <= '0;
    end else begin
      if (exc_take) begin
        cause_q <= exc_cause;
        epc_q   <= exc_pc;
      end else if (wr_ok) begin
        case (wr_idx)
          IX_CAUSE: cause_q <= wr_data;
          IX_EPC:   epc_q   <= wr_data;
          IX_VEC:   vec_q   <= wr_data;
          default: ;
        endcase
      end
    end
  end

  assign cause_o = cause_q;
  assign epc_o   = epc_q;
  assign vec_o   = vec_q;

  // R11: capture of cause and faulting address
  assert_exc_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (cause_q == $past(exc_cause) && epc_q == $past(exc_pc)));
  // R12: vector base is untouched when an exception collides with a write
  assert_exc_prio_R12: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> $stable(vec_q));
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int unsigned CORE_ID    = 4,
  parameter int unsigned CORE_COUNT = 8,
  parameter bit          HAS_MMU    = 1'b1,
  parameter bit          HAS_CCU    = 1'b0,
  parameter bit          HAS_FPU    = 1'b1,
  parameter bit          HAS_VPU    = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_idx,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_idx,
  output logic [31:0] rd_data,
  input  logic        exc_take,
  input  logic [31:0] exc_cause,
  input  logic [31:0] exc_pc,
  output logic [1:0]  mode,
  output logic        priv_fault
);
  localparam logic [NUNITS-1:0] PRES_MASK = {HAS_VPU, HAS_FPU, HAS_CCU, HAS_MMU, 1'b0, 1'b1};
  localparam logic [ID_FLD_W-1:0] ID_NUM  = ID_FLD_W'(CORE_ID);
  localparam logic [ID_FLD_W-1:0] ID_CNT  = ID_FLD_W'(CORE_COUNT);
  localparam logic [XLEN-1:0] IDENT_WORD  = {{(XLEN-2*ID_FLD_W){1'b0}}, ID_CNT, ID_NUM};

  mode_e           mode_s;
  logic            wr_ok;
  logic [XLEN-1:0] feat_w, cause_w, epc_w, vec_w;

  sysctl_mode_ctl u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_req       (wr_en),
    .wr_ctrl      (wr_idx == IX_CTRL),
    .wr_mode      (wr_data[1:0]),
    .exc_take     (exc_take),
    .mode_o       (mode_s),
    .wr_ok_o      (wr_ok),
    .priv_fault_o (priv_fault)
  );

  sysctl_feature #(.PRESENT(PRES_MASK)) u_feat (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_feat    (wr_ok && wr_idx == IX_FEAT),
    .wr_en_bits (wr_data[EN_LSB +: NUNITS]),
    .feat_word  (feat_w)
  );

  sysctl_exc_regs u_exc (
    .clk       (clk),
    .rst_n     (rst_n),
    .exc_take  (exc_take),
    .exc_cause (exc_cause),
    .exc_pc    (exc_pc),
    .wr_ok     (wr_ok),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .cause_o   (cause_w),
    .epc_o     (epc_w),
    .vec_o     (vec_w)
  );

  always_comb begin
    case (rd_idx)
      IX_CTRL:  rd_data = {{(XLEN-2){1'b0}}, mode_s};
      IX_RSVD:  rd_data = '0;
      IX_VER:   rd_data = VERSION_WORD;
      IX_IDENT: rd_data = IDENT_WORD;
      IX_FEAT:  rd_data = feat_w;
      IX_CAUSE: rd_data = cause_w;
      IX_EPC:   rd_data = epc_w;
      default:  rd_data = vec_w;
    endcase
  end

  assign mode = mode_s;

  // R10: a refused write never moves the mode
  assert_fault_keeps_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault |-> (mode == $past(mode) || $past(exc_take)));
endmodule

// File: tb/sysctl_regs_test.sv
module sysctl_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        exc_take = 1'b0;
  logic [31:0] exc_cause = '0;
  logic [31:0] exc_pc = '0;
  logic [1:0]  mode;
  logic        priv_fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [1:0]  m_mode;
  logic [31:0] m_cause, m_epc, m_vec;
  logic [5:0]  m_en;
  localparam logic [5:0] PRES = 6'b010101;

  always #10 clk = ~clk;

  sysctl_regs uut (.*);

  function automatic logic [31:0] expect_reg(input logic [2:0] i);
    case (i)
      3'd0: return {30'b0, m_mode};
      3'd1: return 32'h0;
      3'd2: return 32'h7233_7600;
      3'd3: return 32'h0000_8004;
      3'd4: return {10'b0, m_en | 6'b000001, 10'b0, PRES};
      3'd5: return m_cause;
      3'd6: return m_epc;
      default: return m_vec;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] i);
    case (i)
      3'd0: return "R3";
      3'd1: return "R9";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R8";
      default: return "R13";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 8; i++) begin
      rd_idx = 3'(i);
      #1;
      check((req == "") ? req_of(3'(i)) : req, rd_data, expect_reg(3'(i)));
    end
    check("R2", {30'b0, mode}, {30'b0, m_mode});
  endtask

  // one access cycle; inputs driven away from the edge
  task automatic step(input bit we, input logic [2:0] idx, input logic [31:0] d,
                      input bit ex, input logic [31:0] c, input logic [31:0] pc);
    bit ok, fault;
    wr_en = we; wr_idx = idx; wr_data = d;
    exc_take = ex; exc_cause = c; exc_pc = pc;
    ok    = we && !ex && m_mode[1];
    fault = we && !ex && !m_mode[1];
    @(posedge clk);
    #2;
    wr_en = 1'b0; exc_take = 1'b0;
    if (ex) begin
      m_cause = c; m_epc = pc;
      if (m_mode != 2'b11) m_mode = 2'b10;
    end else if (ok) begin
      case (idx)
        3'd0: m_mode = d[1:0];
        3'd4: m_en = d[21:16] & PRES & 6'b111100;
        3'd5: m_cause = d;
        3'd6: m_epc = d;
        3'd7: m_vec = d;
        default: ;
      endcase
    end
    check(ex && we ? "R12" : "R10", {31'b0, priv_fault}, {31'b0, fault});
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240216));
    m_mode = 2'b10; m_cause = '0; m_epc = '0; m_vec = '0; m_en = '0;
    #35 rst_n = 1'b1;
    #10;
    check_all("R1");

    // R4 R5 R9 R3 R6 R13: write all ones everywhere from kernel, mode last
    for (int i = 1; i < 8; i++) step(1, 3'(i), 32'hFFFF_FFFF, 0, 0, 0);
    check_all("");
    step(1, 3'd0, 32'hFFFF_FFFF, 0, 0, 0);
    check_all("R3");
    // R11: exception in hypervisor keeps hypervisor
    step(0, 3'd0, 0, 1, 32'h0000_0011, 32'h1000_0040);
    check_all("R11");
    // R8: clear enables
    step(1, 3'd4, 32'h0, 0, 0, 0);
    check_all("R8");
    // R10: drop to user, refused writes
    step(1, 3'd0, 32'h0, 0, 0, 0);
    step(1, 3'd7, 32'h1234_5678, 0, 0, 0);
    step(1, 3'd0, 32'h3, 0, 0, 0);
    check_all("R10");
    // R11 R12: exception collides with write in user mode
    step(1, 3'd7, 32'hDEAD_BEEF, 1, 32'h5, 32'h2000_0004);
    check_all("R12");
    // R12 from kernel: write lost, no fault
    step(1, 3'd5, 32'hCAFE_0000, 1, 32'h7, 32'h3000_0008);
    check_all("R12");

    for (int n = 0; n < 400; n++) begin
      int unsigned r;
      r = $urandom % 8;
      step($urandom % 4 != 0, 3'(r == 0 ? 0 : $urandom % 8), $urandom,
           ($urandom % 7) == 0, $urandom, $urandom);
      if (n % 8 == 0) check_all("");
    end
    check_all("");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule